// File: doc/BRIEF.md
# Floating-Point Rounding and Exception-Flag Control Register

This block keeps the architectural control word of a floating-point unit. It holds two fields: a 3-bit dynamic rounding mode and a 5-bit sticky set of exception flags. Software reaches the word through three access views: the whole 32-bit word, the rounding mode alone, or the flags alone. Each view can be read, swapped with a register operand, or swapped with a 5-bit immediate. A swap returns the value the view held before the access, in the same cycle. The new value is written at the next clock edge.

Alongside the access port, the block resolves the 3-bit rounding field of each executing instruction into an effective rounding mode. It flags that instruction as illegal when the resolved mode is a reserved code. It also merges the exception outcome of every completing floating-point operation into the flags by OR. The flags stay set until software overwrites them. Exceptions never cause a trap here.

Top module: `fpu_ctl_reg`

## Requirements
- R1: After reset (rst_n low) the rounding mode is 000 and all five flags are 0.
- R2: The whole-word view (acc_view 00) reads rounding mode in bits 7..5 and flags in bits 4..0, with bits 31..8 always zero. Writes to bits 31..8 are ignored.
- R3: The rounding-mode view (acc_view 01) reads the mode in bits 2..0 with all other bits zero. A write takes bits 2..0 of the source.
- R4: The flags view (acc_view 10) reads the flags in bits 4..0 with all other bits zero. The flags are ordered from bit 4 to bit 0 as invalid, divide-by-zero, overflow, underflow, inexact. A write takes bits 4..0 of the source.
- R5: A swap with a register source (acc_op 01) presents the old view value on acc_rdata in the access cycle. The new value is stored from acc_wdata at the next rising edge.
- R6: A swap with an immediate source (acc_op 10) uses acc_imm zero-extended as the source. In the whole-word view this sets the flags to the immediate and the mode to 000.
- R7: acc_op 00 and 11 only read; neither changes any state.
- R8: acc_view 11 reads as zero and never changes state, whatever acc_op is.
- R9: While flag_valid is high, flag_in is ORed into the flags at the next edge. A flag, once set, stays set until a write to the flags.
- R10: When an access writes the flags in the same cycle as an accrual, the written value wins. A write to the rounding-mode view alone does not block the accrual.
- R11: The effective mode eff_rm is ins_rm, except that ins_rm 111 selects the stored dynamic mode. Codes: 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest-max-magnitude.
- R12: rm_illegal is high exactly when ins_uses_rm is high and the effective mode is 101, 110 or 111. This includes a dynamic selection while the stored mode holds one of those codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_view | input | 2 | 00 whole word, 01 rounding mode, 10 flags, 11 reserved |
| acc_op | input | 2 | 00 read, 01 swap with register, 10 swap with immediate, 11 read |
| acc_wdata | input | 32 | Register source for a swap |
| acc_imm | input | 5 | Immediate source for a swap |
| acc_rdata | output | 32 | Old value of the selected view; zero when idle |
| flag_valid | input | 1 | A completing operation reports exceptions |
| flag_in | input | 5 | Exception bits of that operation |
| ins_rm | input | 3 | Rounding field of the executing instruction |
| ins_uses_rm | input | 1 | The executing instruction rounds |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Resolved mode is reserved for a rounding instruction |

## Verification
The hardest situation to reach is an access that writes the flags in the very cycle a completing operation reports exceptions. The winner of that collision is visible only one cycle later. The bench drives both strobes on the same falling edge. It then reads the flags back through the access port, so the collision is checked entirely at the ports. A second collision is also covered: a rounding-mode-only write paired with an accrual, where both updates must land. Reaching the illegal dynamic case means first storing a reserved mode through a swap, and only then presenting ins_rm 111.

// File: rtl/fcu_pkg.sv
`timescale 1ns/1ps
// Shared widths, field positions and encodings for the FP control register.
package fcu_pkg;
    localparam int MODE_W  = 3;
    localparam int FLAG_W  = 5;
    localparam int IMM_W   = 5;
    localparam int FIELD_W = MODE_W + FLAG_W;
    localparam int FLAG_LO = 0;
    localparam int MODE_LO = FLAG_W;

    typedef enum logic [1:0] {
        VIEW_WORD  = 2'b00,
        VIEW_MODE  = 2'b01,
        VIEW_FLAGS = 2'b10,
        VIEW_NONE  = 2'b11
    } view_e;

    typedef enum logic [1:0] {
        OP_READ     = 2'b00,
        OP_SWAP_REG = 2'b01,
        OP_SWAP_IMM = 2'b10,
        OP_PEEK     = 2'b11
    } op_e;

    typedef enum logic [MODE_W-1:0] {
        RND_NEAR_EVEN = 3'b000,
        RND_ZERO      = 3'b001,
        RND_DOWN      = 3'b010,
        RND_UP        = 3'b011,
        RND_NEAR_MAX  = 3'b100,
        RND_RSV5      = 3'b101,
        RND_RSV6      = 3'b110,
        RND_DYNAMIC   = 3'b111
    } rnd_e;

    localparam logic [MODE_W-1:0] RND_LAST_LEGAL = RND_NEAR_MAX;
endpackage

// File: rtl/fcu_view_port.sv
`timescale 1ns/1ps
// Access-view decoder: selects the old value of the addressed view for read
// and forms per-field write enables and values for swaps.
// Assumes the caller samples acc_rdata combinationally in the access cycle.
module fcu_view_port
    import fcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              acc_en,
    input  logic [1:0]        acc_view,
    input  logic [1:0]        acc_op,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [IMM_W-1:0]  acc_imm,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [FLAG_W-1:0] cur_flags,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              mode_we,
    output logic [MODE_W-1:0] mode_wval,
    output logic              flags_we,
    output logic [FLAG_W-1:0] flags_wval
);
    localparam int RSV_W = DATA_W - FIELD_W;

    logic [FIELD_W-1:0] src_low;
    logic               is_swap;
    view_e              view;
    op_e                op;

    assign view = view_e'(acc_view);
    assign op   = op_e'(acc_op);

    // Pick the swap source: low field bits of the register or the zero-extended immediate.
    always_comb begin
        src_low = '0;
        if (op == OP_SWAP_IMM) src_low[IMM_W-1:0] = acc_imm;
        else                   src_low = acc_wdata[FIELD_W-1:0];
    end

    assign is_swap = acc_en && (op == OP_SWAP_REG || op == OP_SWAP_IMM);

    // Present the pre-access value of the selected view.
    always_comb begin
        acc_rdata = '0;
        if (acc_en) begin
            unique case (view)
                VIEW_WORD:  acc_rdata = {{RSV_W{1'b0}}, cur_mode, cur_flags};
                VIEW_MODE:  acc_rdata[MODE_W-1:0] = cur_mode;
                VIEW_FLAGS: acc_rdata[FLAG_W-1:0] = cur_flags;
                default:    acc_rdata = '0;
            endcase
        end
    end

    // Form field write requests from the addressed view.
    always_comb begin
        mode_we    = 1'b0;
        flags_we   = 1'b0;
        mode_wval  = '0;
        flags_wval = '0;
        if (is_swap) begin
            unique case (view)
                VIEW_WORD: begin
                    mode_we    = 1'b1;
                    flags_we   = 1'b1;
                    mode_wval  = src_low[MODE_LO +: MODE_W];
                    flags_wval = src_low[FLAG_LO +: FLAG_W];
                end
                VIEW_MODE: begin
                    mode_we   = 1'b1;
                    mode_wval = src_low[MODE_W-1:0];
                end
                VIEW_FLAGS: begin
                    flags_we   = 1'b1;
                    flags_wval = src_low[FLAG_W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcu_state.sv
`timescale 1ns/1ps
// Storage for the rounding mode and the sticky flags. A software write of a
// field overrides any accrual into that field in the same cycle.
// Assumes synchronous active-low reset.
module fcu_state
    import fcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wval,
    input  logic              flags_we,
    input  logic [FLAG_W-1:0] flags_wval,
    input  logic              flag_valid,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [MODE_W-1:0] mode_q,
    output logic [FLAG_W-1:0] flags_q
);
    // Hold the dynamic rounding mode.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= RND_NEAR_EVEN;
        else if (mode_we) mode_q <= mode_wval;
    end

    // One sticky cell per exception flag.
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                        flags_q[i] <= 1'b0;
            else if (flags_we)                 flags_q[i] <= flags_wval[i];
            else if (flag_valid && flag_in[i]) flags_q[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/fcu_rm_resolve.sv
`timescale 1ns/1ps
// Resolves an instruction rounding field against the stored dynamic mode and
// marks reserved results as illegal for rounding instructions.
// Uses the stored mode before any write in the same cycle.
module fcu_rm_resolve
    import fcu_pkg::*;
(
    input  logic [MODE_W-1:0] ins_rm,
    input  logic              ins_uses_rm,
    input  logic [MODE_W-1:0] dyn_mode,
    output logic [MODE_W-1:0] eff_rm,
    output logic              rm_illegal
);
    // Substitute the dynamic mode when the instruction asks for it.
    always_comb begin
        eff_rm = (ins_rm == RND_DYNAMIC) ? dyn_mode : ins_rm;
    end

    // Reject any reserved effective code on instructions that round.
    always_comb begin
        rm_illegal = ins_uses_rm && (eff_rm > RND_LAST_LEGAL);
    end
endmodule

// File: rtl/fpu_ctl_reg.sv
`timescale 1ns/1ps
// Top of the floating-point control register: access views, flag accrual
// and rounding-mode resolution. Assumes one access per cycle.
module fpu_ctl_reg
    import fcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [1:0]        acc_view,
    input  logic [1:0]        acc_op,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [IMM_W-1:0]  acc_imm,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              flag_valid,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic [MODE_W-1:0] ins_rm,
    input  logic              ins_uses_rm,
    output logic [MODE_W-1:0] eff_rm,
    output logic              rm_illegal
);
    logic [MODE_W-1:0] mode_q;
    logic [FLAG_W-1:0] flags_q;
    logic              mode_we;
    logic              flags_we;
    logic [MODE_W-1:0] mode_wval;
    logic [FLAG_W-1:0] flags_wval;

    fcu_view_port #(.DATA_W(DATA_W)) u_view (
        .acc_en     (acc_en),
        .acc_view   (acc_view),
        .acc_op     (acc_op),
        .acc_wdata  (acc_wdata),
        .acc_imm    (acc_imm),
        .cur_mode   (mode_q),
        .cur_flags  (flags_q),
        .acc_rdata  (acc_rdata),
        .mode_we    (mode_we),
        .mode_wval  (mode_wval),
        .flags_we   (flags_we),
        .flags_wval (flags_wval)
    );

    fcu_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wval  (mode_wval),
        .flags_we   (flags_we),
        .flags_wval (flags_wval),
        .flag_valid (flag_valid),
        .flag_in    (flag_in),
        .mode_q     (mode_q),
        .flags_q    (flags_q)
    );

    fcu_rm_resolve u_rm (
        .ins_rm      (ins_rm),
        .ins_uses_rm (ins_uses_rm),
        .dyn_mode    (mode_q),
        .eff_rm      (eff_rm),
        .rm_illegal  (rm_illegal)
    );
endmodule

// File: rtl/fpu_ctl_reg_chk.sv
`timescale 1ns/1ps
// Property checker for fpu_ctl_reg, attached by bind below.
module fpu_ctl_reg_chk
    import fcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic [1:0]        acc_view,
    input logic [1:0]        acc_op,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              flag_valid,
    input logic [FLAG_W-1:0] flag_in,
    input logic [MODE_W-1:0] ins_rm,
    input logic              ins_uses_rm,
    input logic [MODE_W-1:0] eff_rm,
    input logic              rm_illegal,
    input logic [MODE_W-1:0] mode_q,
    input logic [FLAG_W-1:0] flags_q
);
    logic flags_written;
    assign flags_written = acc_en && (acc_op == 2'b01 || acc_op == 2'b10)
                        && (acc_view == 2'b00 || acc_view == 2'b10);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && flags_q == '0));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_view == 2'b00) |-> (acc_rdata[DATA_W-1:FIELD_W] == '0));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_written |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R9
    accrue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_valid && !flags_written) |=> ((flags_q & $past(flag_in)) == $past(flag_in)));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_view == 2'b10 && acc_op == 2'b01) |=> (flags_q == $past(acc_wdata[FLAG_W-1:0])));

    // R11
    dynamic_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_rm == 3'b111) |-> (eff_rm == mode_q));

    // R12
    illegal_dyn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_uses_rm && ins_rm == 3'b111 && mode_q > 3'b100) |-> rm_illegal);

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_uses_rm |-> !rm_illegal);
endmodule

bind fpu_ctl_reg fpu_ctl_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_en      (acc_en),
    .acc_view    (acc_view),
    .acc_op      (acc_op),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .flag_valid  (flag_valid),
    .flag_in     (flag_in),
    .ins_rm      (ins_rm),
    .ins_uses_rm (ins_uses_rm),
    .eff_rm      (eff_rm),
    .rm_illegal  (rm_illegal),
    .mode_q      (mode_q),
    .flags_q     (flags_q)
);

// File: tb/sim_fpu_ctl_reg.sv
`timescale 1ns/1ps
module sim_fpu_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [1:0]  acc_view = '0;
    logic [1:0]  acc_op = '0;
    logic [31:0] acc_wdata = '0;
    logic [4:0]  acc_imm = '0;
    logic [31:0] acc_rdata;
    logic        flag_valid = 1'b0;
    logic [4:0]  flag_in = '0;
    logic [2:0]  ins_rm = '0;
    logic        ins_uses_rm = 1'b0;
    logic [2:0]  eff_rm;
    logic        rm_illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fpu_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_view(acc_view),
        .acc_op(acc_op), .acc_wdata(acc_wdata), .acc_imm(acc_imm),
        .acc_rdata(acc_rdata), .flag_valid(flag_valid), .flag_in(flag_in),
        .ins_rm(ins_rm), .ins_uses_rm(ins_uses_rm), .eff_rm(eff_rm),
        .rm_illegal(rm_illegal)
    );

    // {view, op, wdata, imm, expected old value}
    localparam int NVEC = 17;
    localparam logic [72:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h00000000},
        {2'd0, 2'd1, 32'hFFFFFF6B, 5'h00, 32'h00000000},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h0000006B},
        {2'd1, 2'd0, 32'h00000000, 5'h00, 32'h00000003},
        {2'd2, 2'd0, 32'h00000000, 5'h00, 32'h0000000B},
        {2'd1, 2'd1, 32'hFFFFFFF1, 5'h00, 32'h00000003},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h0000002B},
        {2'd2, 2'd2, 32'h00000000, 5'h14, 32'h0000000B},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h00000034},
        {2'd1, 2'd2, 32'h00000000, 5'h1E, 32'h00000001},
        {2'd1, 2'd0, 32'h00000000, 5'h00, 32'h00000006},
        {2'd0, 2'd2, 32'h00000000, 5'h03, 32'h000000D4},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h00000003},
        {2'd2, 2'd1, 32'h00000000, 5'h00, 32'h00000003},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h00000000},
        {2'd0, 2'd3, 32'hFFFFFFFF, 5'h1F, 32'h00000000},
        {2'd0, 2'd0, 32'h00000000, 5'h00, 32'h00000000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One access cycle, optionally with an accrual; returns the old view value.
    task automatic access(input logic [1:0] v, input logic [1:0] o, input logic [31:0] wd,
                          input logic [4:0] im, input logic fv, input logic [4:0] fi,
                          output logic [31:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_view = v; acc_op = o; acc_wdata = wd; acc_imm = im;
        flag_valid = fv; flag_in = fi;
        #1 rd = acc_rdata;
        @(posedge clk);
        #1 acc_en = 1'b0; flag_valid = 1'b0; flag_in = '0;
    endtask

    task automatic resolve(input logic [2:0] r, input logic u, input string tag,
                           input logic [2:0] exp_rm, input logic exp_ill);
        @(negedge clk);
        ins_rm = r; ins_uses_rm = u;
        #1;
        check(tag, {29'd0, eff_rm}, {29'd0, exp_rm});
        check(tag, {31'd0, rm_illegal}, {31'd0, exp_ill});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state seen through the port and the resolver
        access(2'd0, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R1 word after reset", rd, 32'h0);
        resolve(3'b111, 1'b1, "R1 dynamic after reset", 3'b000, 1'b0);

        // R5: table walk over views and swap forms
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][72:71], VEC[i][70:69], VEC[i][68:37], VEC[i][36:32], 1'b0, '0, rd);
            check($sformatf("R5 row %0d", i), rd, VEC[i][31:0]);
        end

        // R2: high bits ignored, layout of the whole word
        access(2'd0, 2'd1, 32'hFFFFFFFF, '0, 1'b0, '0, rd);
        access(2'd0, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R2 reserved bits zero", rd, 32'h000000FF);
        // R6: whole-word immediate clears mode
        access(2'd0, 2'd2, 32'hFFFFFFFF, 5'h00, 1'b0, '0, rd);
        check("R6 imm swap old", rd, 32'h000000FF);
        access(2'd0, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R6 imm word result", rd, 32'h0);

        // R3: mode view low bits only
        access(2'd1, 2'd1, 32'hFFFFFFFC, '0, 1'b0, '0, rd);
        access(2'd1, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R3 mode view", rd, 32'h4);

        // R4: flags view, then word layout
        access(2'd2, 2'd2, '0, 5'h1F, 1'b0, '0, rd);
        access(2'd2, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R4 flags view", rd, 32'h1F);
        access(2'd0, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R2 word layout", rd, 32'h9F);
        access(2'd2, 2'd2, '0, 5'h00, 1'b0, '0, rd);

        // R8: reserved view
        access(2'd3, 2'd1, 32'hFFFFFFFF, 5'h1F, 1'b0, '0, rd);
        check("R8 reserved view reads zero", rd, 32'h0);
        access(2'd0, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R8 reserved view no write", rd, 32'h80);

        // R7: peek op does not write
        access(2'd1, 2'd3, 32'h0, 5'h0, 1'b0, '0, rd);
        check("R7 peek returns value", rd, 32'h4);
        access(2'd1, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R7 peek left mode", rd, 32'h4);

        // R11 and R12: resolution and illegal detection
        resolve(3'b111, 1'b1, "R11 dynamic legal", 3'b100, 1'b0);
        resolve(3'b010, 1'b1, "R11 static", 3'b010, 1'b0);
        resolve(3'b101, 1'b1, "R12 static reserved", 3'b101, 1'b1);
        access(2'd1, 2'd2, '0, 5'h05, 1'b0, '0, rd);
        resolve(3'b111, 1'b1, "R12 dynamic 101", 3'b101, 1'b1);
        resolve(3'b111, 1'b0, "R12 no rounding use", 3'b101, 1'b0);
        resolve(3'b000, 1'b1, "R11 static over bad dynamic", 3'b000, 1'b0);
        access(2'd1, 2'd2, '0, 5'h07, 1'b0, '0, rd);
        resolve(3'b111, 1'b1, "R12 dynamic 111", 3'b111, 1'b1);
        access(2'd1, 2'd2, '0, 5'h06, 1'b0, '0, rd);
        resolve(3'b111, 1'b1, "R12 dynamic 110", 3'b110, 1'b1);
        access(2'd1, 2'd2, '0, 5'h00, 1'b0, '0, rd);
        @(negedge clk); ins_uses_rm = 1'b0; ins_rm = '0;

        // R9: accrual and stickiness
        access(2'd3, 2'd0, '0, '0, 1'b1, 5'h01, rd);
        access(2'd3, 2'd0, '0, '0, 1'b1, 5'h10, rd);
        access(2'd2, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R9 accrued OR", rd, 32'h11);
        access(2'd3, 2'd0, '0, '0, 1'b1, 5'h00, rd);
        access(2'd2, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R9 sticky after empty report", rd, 32'h11);

        // R10: write versus accrual in one cycle
        access(2'd2, 2'd2, '0, 5'h04, 1'b1, 5'h01, rd);
        check("R10 old flags returned", rd, 32'h11);
        access(2'd2, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R10 flags write wins", rd, 32'h04);
        access(2'd1, 2'd2, '0, 5'h03, 1'b1, 5'h08, rd);
        access(2'd2, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R10 mode write lets accrual in", rd, 32'h0C);
        access(2'd1, 2'd0, '0, '0, 1'b0, '0, rd);
        check("R10 mode write landed", rd, 32'h03);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule